// File: doc/BRIEF.md
# Registered Sixteen-Operation Arithmetic-Logic Unit

This block is a single-cycle, clocked arithmetic-logic unit. It takes two operands and a 4-bit operation code. Every result is a registered value: the data word and three status flags are captured on the rising clock edge after the inputs are sampled.

The operation set has sixteen entries. It covers two-operand and one-operand arithmetic (add, subtract, increment, decrement, multiply), a flags-only compare, bitwise logic and complement, and two rotates whose distance comes from the low bits of the second operand. It also has a conditional clear, which zeroes the result only when the operands match. A synchronous clear input overrides all of this and zeroes every output register.

The data width and the rotator structure are parameters. Opcode decoding is inside the block. Multiply completes within the same cycle as every other operation.

Top module: `reg_alu`

## Requirements
- R1: When `clr` is high at a rising edge, `result`, `flag_c`, `flag_v` and `flag_z` all become 0 on that edge, whatever the opcode.
- R2: Opcode encoding: 0 add, 1 subtract, 2 compare, 3 increment A, 4 increment B, 5 decrement A, 6 decrement B, 7 multiply, 8 AND, 9 OR, 10 XOR, 11 complement A, 12 complement B, 13 rotate left, 14 rotate right, 15 conditional clear.
- R3: Add, subtract, increment and decrement wrap modulo 2^DATA_W. `flag_c` holds the carry out for add and increment, and the borrow (A<B unsigned, or operand equal to 0) for subtract and decrement. `flag_v` is signed two's-complement overflow.
- R4: Compare leaves `result` unchanged. It sets `flag_c` and `flag_v` as subtract A−B would, and sets `flag_z` when A equals B.
- R5: Multiply puts the low DATA_W bits of the unsigned product A·B on `result`. `flag_c` is set when the upper half of the product is nonzero, and `flag_v` is 0.
- R6: AND, OR, XOR and the two complements produce the bitwise result, with `flag_c` = `flag_v` = 0.
- R7: Rotate left moves the top bit into bit 0 at each step, and rotate right moves bit 0 into the top bit. The distance is B[2:0] (0 to 7 at DATA_W=8), and the higher bits of B have no effect. `flag_c` = `flag_v` = 0.
- R8: The conditional clear gives `result` = 0 when A equals B and holds the previous `result` otherwise, with `flag_c` = `flag_v` = 0.
- R9: For every opcode except compare, `flag_z` is 1 exactly when the new `result` is 0.
- R10: Outputs reflect the inputs sampled at the previous rising edge, so the latency is one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| clr | input | 1 | Synchronous clear of result and flags |
| opa | input | DATA_W | Operand A |
| opb | input | DATA_W | Operand B; low bits give the rotate distance |
| opcode | input | 4 | Operation select |
| result | output | DATA_W | Registered result |
| flag_c | output | 1 | Carry, borrow or product-overflow flag |
| flag_v | output | 1 | Signed overflow flag |
| flag_z | output | 1 | Zero flag |

## Verification
The bench builds the block with DATA_W=8 and the log-stage barrel rotator, which is the default. At that width every wrap point (0x7F, 0x80, 0xFF, 0x00) can be reached with directed operands. All eight rotate distances can be checked one by one, and B values with high bits set show that only B[2:0] selects the distance. The 8-bit product makes the upper-half carry of the multiply easy to trigger and to avoid.

// File: rtl/reg_alu_pkg.sv
package reg_alu_pkg;
   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_SUB  = 4'd1,
      OP_CMP  = 4'd2,
      OP_INCA = 4'd3,
      OP_INCB = 4'd4,
      OP_DECA = 4'd5,
      OP_DECB = 4'd6,
      OP_MUL  = 4'd7,
      OP_AND  = 4'd8,
      OP_OR   = 4'd9,
      OP_XOR  = 4'd10,
      OP_NOTA = 4'd11,
      OP_NOTB = 4'd12,
      OP_ROL  = 4'd13,
      OP_ROR  = 4'd14,
      OP_CLRQ = 4'd15
   } op_e;
endpackage

// File: rtl/reg_alu_addsub.sv
// Shared adder for add, subtract, compare, increment and decrement.
module reg_alu_addsub
   import reg_alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  op_e               op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] sum,
   output logic              cy,
   output logic              ov
);
   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] x, y, y_eff;
   logic              inv;
   logic [DATA_W:0]   total;

   always_comb begin
      x   = a;
      y   = b;
      inv = 1'b0;
      case (op)
         OP_SUB, OP_CMP: inv = 1'b1;
         OP_INCA:        y = DATA_W'(1);
         OP_INCB: begin  x = b; y = DATA_W'(1); end
         OP_DECA: begin  y = DATA_W'(1); inv = 1'b1; end
         OP_DECB: begin  x = b; y = DATA_W'(1); inv = 1'b1; end
         default: ;
      endcase
   end

   assign y_eff = inv ? ~y : y;
   assign total = {1'b0, x} + {1'b0, y_eff} + {{DATA_W{1'b0}}, inv};
   assign sum   = total[MSB:0];
   // carry out for additions; inverted carry is the borrow for subtractions
   assign cy    = total[DATA_W] ^ inv;
   assign ov    = (x[MSB] == y_eff[MSB]) && (sum[MSB] != x[MSB]);
endmodule

// File: rtl/reg_alu_rot.sv
// Rotator; BARREL selects log-stage muxes or a doubled-word shift.
module reg_alu_rot #(
   parameter int DATA_W = 8,
   parameter bit BARREL = 1'b1
) (
   input  logic [DATA_W-1:0]         din,
   input  logic [$clog2(DATA_W)-1:0] amt,
   input  logic                      right,
   output logic [DATA_W-1:0]         dout
);
   localparam int AW = $clog2(DATA_W);

   generate
      if (BARREL) begin : g_barrel
         logic [DATA_W-1:0] stg [AW+1];
         assign stg[0] = din;
         for (genvar k = 0; k < AW; k++) begin : g_stage
            localparam int SH = 1 << k;
            logic [DATA_W-1:0] l_rot, r_rot;
            assign l_rot = {stg[k][DATA_W-1-SH:0], stg[k][DATA_W-1:DATA_W-SH]};
            assign r_rot = {stg[k][SH-1:0], stg[k][DATA_W-1:SH]};
            assign stg[k+1] = amt[k] ? (right ? r_rot : l_rot) : stg[k];
         end
         assign dout = stg[AW];
      end else begin : g_double
         logic [2*DATA_W-1:0] dbl, l_sh, r_sh;
         assign dbl  = {din, din};
         assign l_sh = dbl << amt;
         assign r_sh = dbl >> amt;
         assign dout = right ? r_sh[DATA_W-1:0] : l_sh[2*DATA_W-1:DATA_W];
      end
   endgenerate
endmodule

// File: rtl/reg_alu.sv
module reg_alu
   import reg_alu_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter bit ROT_BARREL = 1'b1
) (
   input  logic              clk,
   input  logic              clr,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [3:0]        opcode,
   output logic [DATA_W-1:0] result,
   output logic              flag_c,
   output logic              flag_v,
   output logic              flag_z
);
   localparam int AW = $clog2(DATA_W);

   initial begin
      assert (DATA_W >= 4 && (1 << AW) == DATA_W)
         else $error("reg_alu: DATA_W must be a power of two, at least 4");
   end

   op_e                 op;
   logic [DATA_W-1:0]   as_sum, rot_out;
   logic                as_cy, as_ov;
   logic [2*DATA_W-1:0] prod;
   logic [DATA_W-1:0]   y_q, y_n;
   logic                c_q, v_q, z_q, c_n, v_n, z_n;

   assign op   = op_e'(opcode);
   assign prod = opa * opb;

   reg_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
      .op(op), .a(opa), .b(opb), .sum(as_sum), .cy(as_cy), .ov(as_ov)
   );

   reg_alu_rot #(.DATA_W(DATA_W), .BARREL(ROT_BARREL)) u_rot (
      .din(opa), .amt(opb[AW-1:0]), .right(op == OP_ROR), .dout(rot_out)
   );

   always_comb begin
      y_n = y_q;
      c_n = 1'b0;
      v_n = 1'b0;
      case (op)
         OP_ADD, OP_SUB, OP_INCA, OP_INCB, OP_DECA, OP_DECB: begin
            y_n = as_sum; c_n = as_cy; v_n = as_ov;
         end
         OP_CMP: begin
            c_n = as_cy; v_n = as_ov;
         end
         OP_MUL: begin
            y_n = prod[DATA_W-1:0];
            c_n = |prod[2*DATA_W-1:DATA_W];
         end
         OP_AND:  y_n = opa & opb;
         OP_OR:   y_n = opa | opb;
         OP_XOR:  y_n = opa ^ opb;
         OP_NOTA: y_n = ~opa;
         OP_NOTB: y_n = ~opb;
         OP_ROL, OP_ROR: y_n = rot_out;
         OP_CLRQ: if (opa == opb) y_n = '0;
         default: ;
      endcase
      z_n = (op == OP_CMP) ? (as_sum == '0) : (y_n == '0);
   end

   always_ff @(posedge clk) begin
      if (clr) begin
         y_q <= '0;
         c_q <= 1'b0;
         v_q <= 1'b0;
         z_q <= 1'b0;
      end else begin
         y_q <= y_n;
         c_q <= c_n;
         v_q <= v_n;
         z_q <= z_n;
      end
   end

   assign result = y_q;
   assign flag_c = c_q;
   assign flag_v = v_q;
   assign flag_z = z_q;
endmodule

// File: rtl/reg_alu_chk.sv
module reg_alu_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              clr,
   input logic [DATA_W-1:0] opa,
   input logic [DATA_W-1:0] opb,
   input logic [3:0]        opcode,
   input logic [DATA_W-1:0] result,
   input logic              flag_c,
   input logic              flag_v,
   input logic              flag_z
);
   localparam int AW = $clog2(DATA_W);

   logic armed = 1'b0;
   always_ff @(posedge clk) if (clr) armed <= 1'b1;

   logic [DATA_W-1:0]   sum_ref, rol_ref;
   logic [2*DATA_W-1:0] dbl;
   assign sum_ref = opa + opb;
   assign dbl     = {opa, opa} << opb[AW-1:0];
   assign rol_ref = dbl[2*DATA_W-1:DATA_W];

   // R1
   a_r1_clear_all: assert property (@(posedge clk)
      clr |=> (result == '0) && !flag_c && !flag_v && !flag_z);

   // R3, R10
   a_r3_add_value: assert property (@(posedge clk) disable iff (clr)
      armed && opcode == 4'd0 |=> result == $past(sum_ref));

   // R4
   a_r4_cmp_holds: assert property (@(posedge clk) disable iff (clr)
      armed && opcode == 4'd2 |=> $stable(result));

   // R6
   a_r6_logic_flags: assert property (@(posedge clk) disable iff (clr)
      armed && opcode >= 4'd8 |=> !flag_c && !flag_v);

   // R7
   a_r7_rol_value: assert property (@(posedge clk) disable iff (clr)
      armed && opcode == 4'd13 |=> result == $past(rol_ref));

   // R8
   a_r8_clrq_hold: assert property (@(posedge clk) disable iff (clr)
      armed && opcode == 4'd15 && opa != opb |=> $stable(result));

   // R9
   a_r9_zero_flag: assert property (@(posedge clk) disable iff (clr)
      armed && opcode != 4'd2 |=> flag_z == (result == '0));
endmodule

bind reg_alu reg_alu_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .clr(clr), .opa(opa), .opb(opb), .opcode(opcode),
   .result(result), .flag_c(flag_c), .flag_v(flag_v), .flag_z(flag_z)
);

// File: tb/reg_alu_bench.sv
`timescale 1ns/1ps
module reg_alu_bench;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          clr = 1'b1;
   logic [DW-1:0] opa = '0, opb = '0;
   logic [3:0]    opcode = 4'd0;
   logic [DW-1:0] result;
   logic          flag_c, flag_v, flag_z;

   int n_tests = 0;
   int n_fail  = 0;
   logic [DW-1:0] y_model = '0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   reg_alu #(.DATA_W(DW), .ROT_BARREL(1'b1)) u_reg_alu (
      .clk(clk), .clr(clr), .opa(opa), .opb(opb), .opcode(opcode),
      .result(result), .flag_c(flag_c), .flag_v(flag_v), .flag_z(flag_z)
   );

   task automatic check(input string req, input string what,
                        input logic [DW-1:0] got, input logic [DW-1:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   function automatic void model(input logic [3:0] op, input logic [DW-1:0] a,
         input logic [DW-1:0] b, input logic [DW-1:0] prev,
         output logic [DW-1:0] y, output logic c, output logic v, output logic z);
      logic [DW:0]     s;
      logic [2*DW-1:0] p;
      logic [DW-1:0]   d;
      y = prev; c = 1'b0; v = 1'b0;
      case (op)
         4'd0: begin s = {1'b0, a} + {1'b0, b}; y = s[DW-1:0]; c = s[DW];
                     v = (a[DW-1] == b[DW-1]) && (y[DW-1] != a[DW-1]); end
         4'd1: begin y = a - b; c = a < b;
                     v = (a[DW-1] != b[DW-1]) && (y[DW-1] != a[DW-1]); end
         4'd2: begin d = a - b; c = a < b;
                     v = (a[DW-1] != b[DW-1]) && (d[DW-1] != a[DW-1]); end
         4'd3: begin y = a + 1'b1; c = (a == 8'hFF); v = (a == 8'h7F); end
         4'd4: begin y = b + 1'b1; c = (b == 8'hFF); v = (b == 8'h7F); end
         4'd5: begin y = a - 1'b1; c = (a == 8'h00); v = (a == 8'h80); end
         4'd6: begin y = b - 1'b1; c = (b == 8'h00); v = (b == 8'h80); end
         4'd7: begin p = a * b; y = p[DW-1:0]; c = (p[2*DW-1:DW] != '0); end
         4'd8:  y = a & b;
         4'd9:  y = a | b;
         4'd10: y = a ^ b;
         4'd11: y = ~a;
         4'd12: y = ~b;
         4'd13: begin y = a; for (int i = 0; i < int'(b[2:0]); i++) y = {y[DW-2:0], y[DW-1]}; end
         4'd14: begin y = a; for (int i = 0; i < int'(b[2:0]); i++) y = {y[0], y[DW-1:1]}; end
         default: if (a == b) y = '0;
      endcase
      z = (op == 4'd2) ? (a == b) : (y == '0);
   endfunction

   // Drive at the falling edge, capture at the rising edge, check at the next falling edge.
   task automatic run_op(input string req, input logic [3:0] op,
                         input logic [DW-1:0] a, input logic [DW-1:0] b);
      logic [DW-1:0] ey;
      logic ec, ev, ez;
      @(negedge clk);
      opa = a; opb = b; opcode = op; clr = 1'b0;
      model(op, a, b, y_model, ey, ec, ev, ez);
      @(negedge clk);
      check(req, "result", result, ey);
      check(req, "flag_c", {7'd0, flag_c}, {7'd0, ec});
      check(req, "flag_v", {7'd0, flag_v}, {7'd0, ev});
      check(req, "flag_z", {7'd0, flag_z}, {7'd0, ez});
      y_model = ey;
   endtask

   task automatic t_reset;
      // R1: initial clear
      @(negedge clk); clr = 1'b1; opcode = 4'd0; opa = 8'h11; opb = 8'h22;
      @(negedge clk);
      check("R1", "result", result, 8'h00);
      check("R1", "flags", {5'd0, flag_c, flag_v, flag_z}, 8'h00);
      y_model = '0;
   endtask

   task automatic t_clr_override;
      // R1: clr wins over a nonzero-producing opcode
      run_op("R10", 4'd0, 8'h40, 8'h05);
      @(negedge clk); clr = 1'b1; opcode = 4'd7; opa = 8'hFF; opb = 8'hFF;
      @(negedge clk);
      check("R1", "override result", result, 8'h00);
      check("R1", "override flags", {5'd0, flag_c, flag_v, flag_z}, 8'h00);
      clr = 1'b0; y_model = '0;
   endtask

   task automatic t_arith;
      run_op("R3", 4'd0, 8'h12, 8'h34);
      run_op("R3", 4'd0, 8'hFF, 8'h01);   // carry, zero
      run_op("R3", 4'd0, 8'h7F, 8'h01);   // signed overflow
      run_op("R3", 4'd1, 8'h05, 8'h09);   // borrow
      run_op("R3", 4'd1, 8'h80, 8'h01);   // signed overflow
      run_op("R3", 4'd3, 8'hFF, 8'h00);
      run_op("R3", 4'd4, 8'h00, 8'h7F);
      run_op("R3", 4'd5, 8'h00, 8'h33);
      run_op("R3", 4'd6, 8'h33, 8'h80);
   endtask

   task automatic t_compare;
      run_op("R2", 4'd9, 8'hA5, 8'h00);   // set a known result
      run_op("R4", 4'd2, 8'h10, 8'h10);   // equal: Z, result held
      run_op("R4", 4'd2, 8'h01, 8'h02);   // borrow
      run_op("R4", 4'd2, 8'h80, 8'h7F);   // overflow
   endtask

   task automatic t_mul;
      run_op("R5", 4'd7, 8'h0C, 8'h0A);
      run_op("R5", 4'd7, 8'h10, 8'h10);   // low byte zero, high nonzero
      run_op("R5", 4'd7, 8'hFF, 8'h02);
   endtask

   task automatic t_logic;
      run_op("R6", 4'd8, 8'hF0, 8'h3C);
      run_op("R6", 4'd9, 8'h00, 8'h00);
      run_op("R6", 4'd10, 8'hAA, 8'hAA);
      run_op("R6", 4'd11, 8'h5A, 8'h00);
      run_op("R6", 4'd12, 8'h00, 8'hFF);
   endtask

   task automatic t_rotate;
      for (int k = 0; k < 8; k++) begin
         run_op("R7", 4'd13, 8'h81, 8'(k));
         run_op("R7", 4'd14, 8'h81, 8'(k));
      end
      // R7: high bits of B have no effect (distance 3 in all cases)
      run_op("R7", 4'd13, 8'h96, 8'hF3);
      run_op("R7", 4'd14, 8'h96, 8'h0B);
   endtask

   task automatic t_clear_op;
      run_op("R2", 4'd0, 8'h21, 8'h21);
      run_op("R8", 4'd15, 8'h3C, 8'h3D);  // differ: hold
      run_op("R8", 4'd15, 8'h3C, 8'h3C);  // equal: zero
   endtask

   task automatic t_sweep;
      logic [DW-1:0] a = 8'h5D, b = 8'hC3;
      for (int i = 0; i < 48; i++) begin
         a = a * 8'd13 + 8'd7;
         b = b * 8'd29 + 8'd3;
         run_op("R9", 4'(i % 16), a, b);
      end
   endtask

   task automatic finish_run;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      t_reset();
      t_arith();
      t_compare();
      t_mul();
      t_logic();
      t_rotate();
      t_clear_op();
      t_clr_override();
      t_sweep();
      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: got hung run expected completion");
         finish_run();
      end
   end
endmodule